// File: doc/BRIEF.md
# Two-Dimensional Line Address Sequencer

This block walks a memory buffer organised as a set of equally sized lines and produces one word address per beat for a memory-side port. Software fills a small set of parameter registers: a base address, a line length in bytes, a number of lines and a stride between line starts. It then writes the go bit. The sequencer emits the words of line 0 from the base address upward. Each following line starts one stride further on. A stride equal to the line length gives one contiguous buffer cut into lines. A stride of zero replays the same line once for every count.

Each finished line raises a sticky end-of-line flag. The last beat of the last line also raises a sticky end-of-window flag. A go request with illegal parameters, or one that arrives while a transfer runs, raises a sticky programming-error flag and starts nothing. Two further flags latch error pulses reported by the surrounding datapath. Every flag has its own enable, and a single interrupt line reports any flag that is both set and enabled.

The memory side is a valid/ready stream. While a transfer is active `mreq_valid` stays high. A beat is consumed only on a cycle where `mreq_ready` is also high. While ready is low, the address and valid hold unchanged, so the consumer may apply back-pressure for any number of cycles.

Top module: `line_dma_seq`

## Requirements
- R1: Beat k of line n carries byte address base + n*stride + k*WORD_BYTES (WORD_BYTES = 4 by default), computed modulo 2^ADDR_W.
- R2: While a transfer is active, `mreq_valid` is high. A beat advances only on a cycle where `mreq_ready` is high. During a stall, the address and valid stay unchanged.
- R3: With a line count of 1, the transfer is one contiguous line, and the stride value has no effect on any address.
- R4: With a stride of 0, every line repeats the addresses of line 0.
- R5: The final beat of each line sets event flag bit 0 (end of line) in the cycle after its handshake.
- R6: Event flag bit 1 (end of window) is set only by the final beat of the last line. `busy` and `mreq_valid` are low from the next cycle on.
- R7: A go request is rejected, and sets flag bit 2 (programming error), if any of these holds: line length is 0, line count is 0, or line length is not a multiple of WORD_BYTES. A rejected request issues no beat.
- R8: A go request while busy sets flag bit 2 and leaves the running transfer unchanged.
- R9: Parameters are captured at go. Register writes during a transfer do not alter its addresses.
- R10: A one-cycle pulse on `dp_uflow` sets flag bit 3, and a pulse on `dp_fault` sets flag bit 4.
- R11: Flags are sticky. Writing select 6 clears every flag whose data bit is 1. A new event in the same cycle as its clear leaves the flag set.
- R12: `irq` is high exactly when some flag is set whose bit in the enable register (select 5) is 1.
- R13: Register selects are: 0 control (bit 0 go, bit 1 direction), 1 base, 2 line bytes, 3 line count, 4 stride. `mreq_write` equals the direction bit captured at go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| mreq_valid | output | 1 | Beat request valid |
| mreq_ready | input | 1 | Beat accepted by memory side |
| mreq_addr | output | ADDR_W | Byte address of the beat |
| mreq_write | output | 1 | Direction of the transfer (1 = write beats) |
| busy | output | 1 | Transfer in progress |
| dp_uflow | input | 1 | Underrun/overflow pulse from datapath |
| dp_fault | input | 1 | Internal error pulse from datapath |
| evt_flags | output | 5 | Sticky event flags |
| irq | output | 1 | OR of set and enabled flags |

## Verification
The main sweep crosses three line lengths, three line counts and four strides on varying base addresses. The strides are zero, equal to the line length, a gap, and a value that wraps the address space. This separates the repeat case, the contiguous case and plain two-dimensional stepping, and checks modulo arithmetic near the top of the space. Each combination runs under a different ready pattern: always ready, alternating, and sparse. A wrong address, a skipped word or a premature advance would each show up differently under these patterns. End-of-line and end-of-window flags are cleared and re-examined at every line boundary. This shows that each line raises its own event and that the window event appears only once, at the end. Separate cases cover each kind of illegal go, a go issued mid-transfer, register rewrites mid-transfer, and clear-versus-set collisions on the flags.

// File: rtl/lds_pkg.sv
package lds_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_LBYTES = 3'd2,
    SEL_LCOUNT = 3'd3,
    SEL_STRIDE = 3'd4,
    SEL_EVEN   = 3'd5,
    SEL_EVCLR  = 3'd6
  } cfg_sel_e;

  localparam int EV_N    = 5;
  localparam int EV_EOL  = 0;
  localparam int EV_EOW  = 1;
  localparam int EV_PERR = 2;
  localparam int EV_UOVF = 3;
  localparam int EV_IERR = 4;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_DIR = 1;

endpackage

// File: rtl/lds_regs.sv
module lds_regs
  import lds_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [SIZE_W-1:0] lbytes_q,
  output logic [CNT_W-1:0]  lcount_q,
  output logic [ADDR_W-1:0] stride_q,
  output logic [EV_N-1:0]   ev_en_q,
  output logic              go_p,
  output logic              dir_p,
  output logic [EV_N-1:0]   clr_mask
);

  cfg_sel_e sel;
  logic     unused_bits;

  assign sel         = cfg_sel_e'(cfg_sel);
  assign unused_bits = ^cfg_wdata;

  assign go_p     = cfg_wr && (sel == SEL_CTRL) && cfg_wdata[CTRL_GO];
  assign dir_p    = cfg_wdata[CTRL_DIR];
  assign clr_mask = (cfg_wr && sel == SEL_EVCLR) ? cfg_wdata[EV_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      lbytes_q <= '0;
      lcount_q <= '0;
      stride_q <= '0;
      ev_en_q  <= '0;
    end else if (cfg_wr) begin
      unique case (sel)
        SEL_BASE:   base_q   <= cfg_wdata[ADDR_W-1:0];
        SEL_LBYTES: lbytes_q <= cfg_wdata[SIZE_W-1:0];
        SEL_LCOUNT: lcount_q <= cfg_wdata[CNT_W-1:0];
        SEL_STRIDE: stride_q <= cfg_wdata[ADDR_W-1:0];
        SEL_EVEN:   ev_en_q  <= cfg_wdata[EV_N-1:0];
        default: ;
      endcase
    end
  end

  AST_REGS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(base_q) && $stable(stride_q) && $stable(ev_en_q)) // R9
    else $error("parameter register changed without a write");

endmodule

// File: rtl/lds_addr_gen.sv
module lds_addr_gen #(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 12,
  parameter int CNT_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_p,
  input  logic              dir_p,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] lbytes_i,
  input  logic [CNT_W-1:0]  lcount_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_write,
  output logic              busy,
  output logic              eol_p,
  output logic              eow_p,
  output logic              perr_p
);

  localparam int                OFS_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
  localparam logic [SIZE_W-1:0] WMASK = SIZE_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(WORD_BYTES);

  logic              busy_q;
  logic              dir_q;
  logic [ADDR_W-1:0] line_base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [SIZE_W-1:0] words_q;
  logic [SIZE_W-1:0] beats_left_q;
  logic [CNT_W-1:0]  lines_left_q;

  logic              bad_cfg;
  logic              launch;
  logic              fire;
  logic              last_beat;
  logic              last_line;
  logic [SIZE_W-1:0] words_in;
  logic [ADDR_W-1:0] next_base;

  assign words_in  = lbytes_i >> OFS_W;
  assign bad_cfg   = (lbytes_i == '0) || (lcount_i == '0) || ((lbytes_i & WMASK) != '0);
  assign launch    = go_p && !busy_q && !bad_cfg;
  assign perr_p    = go_p && (busy_q || bad_cfg);
  assign fire      = busy_q && req_ready;
  assign last_beat = (beats_left_q == '0);
  assign last_line = (lines_left_q == '0);
  assign next_base = line_base_q + stride_q;
  assign eol_p     = fire && last_beat;
  assign eow_p     = eol_p && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      dir_q        <= 1'b0;
      line_base_q  <= '0;
      addr_q       <= '0;
      stride_q     <= '0;
      words_q      <= '0;
      beats_left_q <= '0;
      lines_left_q <= '0;
    end else if (launch) begin
      busy_q       <= 1'b1;
      dir_q        <= dir_p;
      line_base_q  <= base_i;
      addr_q       <= base_i;
      stride_q     <= stride_i;
      words_q      <= words_in;
      beats_left_q <= words_in - 1'b1;
      lines_left_q <= lcount_i - 1'b1;
    end else if (fire) begin
      if (last_beat) begin
        if (last_line) begin
          busy_q <= 1'b0;
        end else begin
          line_base_q  <= next_base;
          addr_q       <= next_base;
          beats_left_q <= words_q - 1'b1;
          lines_left_q <= lines_left_q - 1'b1;
        end
      end else begin
        addr_q       <= addr_q + WSTEP;
        beats_left_q <= beats_left_q - 1'b1;
      end
    end
  end

  assign req_valid = busy_q;
  assign req_addr  = addr_q;
  assign req_write = dir_q;
  assign busy      = busy_q;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr)) // R2
    else $error("request changed during stall");

  AST_STEP_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_beat) |=> (req_addr == $past(req_addr) + WSTEP)) // R1
    else $error("address did not advance by one word");

  AST_EOW_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eow_p |=> !busy && !req_valid) // R6
    else $error("still busy after end of window");

  AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && go_p && bad_cfg) |=> !req_valid) // R7
    else $error("illegal parameters started a transfer");

  AST_BUSY_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && go_p && !fire) |=> busy_q && $stable(req_addr)) // R8
    else $error("go while busy disturbed the transfer");

endmodule

// File: rtl/lds_events.sv
module lds_events
  import lds_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eol_p,
  input  logic            eow_p,
  input  logic            perr_p,
  input  logic            uovf_p,
  input  logic            ierr_p,
  input  logic [EV_N-1:0] clr_mask,
  input  logic [EV_N-1:0] ev_en,
  output logic [EV_N-1:0] flags,
  output logic            irq
);

  logic [EV_N-1:0] set_vec;
  logic [EV_N-1:0] flags_q;

  always_comb begin
    set_vec          = '0;
    set_vec[EV_EOL]  = eol_p;
    set_vec[EV_EOW]  = eow_p;
    set_vec[EV_PERR] = perr_p;
    set_vec[EV_UOVF] = uovf_p;
    set_vec[EV_IERR] = ierr_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | set_vec;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & ev_en);

  AST_EOW_HAS_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    eow_p |-> eol_p) // R6
    else $error("window end without line end");

  AST_PERR_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    perr_p |=> flags[EV_PERR]) // R7
    else $error("programming error not latched");

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[EV_EOL] && !clr_mask[EV_EOL]) |=> flags[EV_EOL]) // R11
    else $error("end-of-line flag dropped without clear");

endmodule

// File: rtl/line_dma_seq.sv
module line_dma_seq
  import lds_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 12,
  parameter int CNT_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic              mreq_write,
  output logic              busy,
  input  logic              dp_uflow,
  input  logic              dp_fault,
  output logic [4:0]        evt_flags,
  output logic              irq
);

  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] lbytes_q;
  logic [CNT_W-1:0]  lcount_q;
  logic [ADDR_W-1:0] stride_q;
  logic [EV_N-1:0]   ev_en_q;
  logic [EV_N-1:0]   clr_mask;
  logic              go_p;
  logic              dir_p;
  logic              eol_p;
  logic              eow_p;
  logic              perr_p;

  lds_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .lbytes_q(lbytes_q), .lcount_q(lcount_q),
    .stride_q(stride_q), .ev_en_q(ev_en_q),
    .go_p(go_p), .dir_p(dir_p), .clr_mask(clr_mask)
  );

  lds_addr_gen #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)
  ) agen_i (
    .clk(clk), .rst_n(rst_n),
    .go_p(go_p), .dir_p(dir_p),
    .base_i(base_q), .lbytes_i(lbytes_q), .lcount_i(lcount_q), .stride_i(stride_q),
    .req_valid(mreq_valid), .req_ready(mreq_ready),
    .req_addr(mreq_addr), .req_write(mreq_write),
    .busy(busy), .eol_p(eol_p), .eow_p(eow_p), .perr_p(perr_p)
  );

  lds_events evt_i (
    .clk(clk), .rst_n(rst_n),
    .eol_p(eol_p), .eow_p(eow_p), .perr_p(perr_p),
    .uovf_p(dp_uflow), .ierr_p(dp_fault),
    .clr_mask(clr_mask), .ev_en(ev_en_q),
    .flags(evt_flags), .irq(irq)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mreq_valid) // R2
    else $error("request while idle");

endmodule

// File: tb/line_dma_seq_tb_top.sv
module line_dma_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [15:0] mreq_addr;
  logic        mreq_write;
  logic        busy;
  logic        dp_uflow = 1'b0;
  logic        dp_fault = 1'b0;
  logic [4:0]  evt_flags;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  int phase  = 0;

  always #2.5 clk = ~clk;

  line_dma_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mreq_addr(mreq_addr), .mreq_write(mreq_write), .busy(busy),
    .dp_uflow(dp_uflow), .dp_fault(dp_fault),
    .evt_flags(evt_flags), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_sel   = 3'(sel);
    cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  // One transfer with the bench computing every address arithmetically.
  task automatic run_xfer(input int base, input int lbytes, input int lcnt,
                          input int stride, input int dir, input logic [7:0] pat,
                          input bit disturb);
    int words = lbytes / 4;
    wr(1, base);
    wr(2, lbytes);
    wr(3, lcnt);
    wr(4, stride);
    wr(6, 31);
    wr(0, 1 + 2 * dir);
    chk("R13 direction", int'(mreq_write), dir);
    for (int ln = 0; ln < lcnt; ln++) begin
      for (int k = 0; k < words; k++) begin
        int exp_a = (base + ln * stride + k * 4) & 16'hFFFF;
        int guard = 0;
        bit done  = 0;
        while (!done && guard < 40) begin
          logic rdy;
          guard++;
          chk("R2 valid held", int'(mreq_valid), 1);
          chk("R1 R3 R4 address", int'(mreq_addr), exp_a);
          rdy = pat[phase % 8];
          phase++;
          mreq_ready = rdy;
          @(posedge clk);
          #1;
          mreq_ready = 1'b0;
          done = rdy;
          if (!done) @(negedge clk);
        end
        if (k == words - 1) begin
          chk("R5 line end flag", int'(evt_flags[0]), 1);
          chk("R6 window flag only at end", int'(evt_flags[1]), (ln == lcnt - 1) ? 1 : 0);
          wr(6, 1);
          chk("R11 clear line flag", int'(evt_flags[0]), 0);
        end else begin
          @(negedge clk);
        end
        if (disturb && ln == 0 && k == 0) begin
          wr(0, 1);       // go while busy
          wr(1, 16'h7770); // rewrite base mid-transfer
          wr(4, 16'h0444);
        end
      end
    end
    chk("R6 busy low", int'(busy), 0);
    chk("R6 valid low", int'(mreq_valid), 0);
    chk("R6 window flag sticky", int'(evt_flags[1]), 1);
    chk("R8 perr flag", int'(evt_flags[2]), disturb ? 1 : 0);
    repeat (3) @(negedge clk);
    chk("R6 no extra beat", int'(mreq_valid), 0);
  endtask

  task automatic bad_go(input int lbytes, input int lcnt);
    wr(2, lbytes);
    wr(3, lcnt);
    wr(6, 31);
    wr(0, 1);
    chk("R7 not busy", int'(busy), 0);
    chk("R7 perr set", int'(evt_flags[2]), 1);
    repeat (3) @(negedge clk);
    chk("R7 no beat", int'(mreq_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pats [3];
    int idx = 0;
    pats[0] = 8'hFF;
    pats[1] = 8'hA5;
    pats[2] = 8'h31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset flags", int'(evt_flags), 0);
    chk("reset busy", int'(busy), 0);
    chk("reset valid", int'(mreq_valid), 0);
    chk("reset irq", int'(irq), 0);

    for (int s = 1; s <= 3; s++) begin
      for (int c = 1; c <= 3; c++) begin
        for (int o = 0; o < 4; o++) begin
          int strides [4];
          int base;
          strides[0] = 0;          // R4 repeat
          strides[1] = s * 4;      // contiguous
          strides[2] = s * 4 + 20; // gap
          strides[3] = 16'hFFF8;   // wraps downward
          base = (idx == 5) ? 16'hFFF8 : 16'h0100 + idx * 36;
          run_xfer(base, s * 4, c, strides[o], idx % 2, pats[idx % 3], 1'b0);
          idx++;
        end
      end
    end

    // R8 and R9: go and parameter rewrites while busy
    run_xfer(16'h0200, 12, 2, 16'h0040, 0, 8'h5B, 1'b1);

    // R7: each illegal combination
    bad_go(0, 2);
    bad_go(8, 0);
    bad_go(6, 2);

    // R10: datapath error pulses
    wr(6, 31);
    @(negedge clk); dp_uflow = 1'b1;
    @(negedge clk); dp_uflow = 1'b0;
    chk("R10 underrun flag", int'(evt_flags[3]), 1);
    @(negedge clk); dp_fault = 1'b1;
    @(negedge clk); dp_fault = 1'b0;
    chk("R10 internal flag", int'(evt_flags[4]), 1);

    // R11: selective clear, and set winning over clear
    wr(6, 8);
    chk("R11 bit3 cleared", int'(evt_flags[3]), 0);
    chk("R11 bit4 kept", int'(evt_flags[4]), 1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'd16; dp_fault = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; dp_fault = 1'b0;
    chk("R11 set wins", int'(evt_flags[4]), 1);

    // R12: interrupt masking, only bit 4 set now
    chk("R12 flags state", int'(evt_flags), 16);
    wr(5, 0);
    chk("R12 irq masked", int'(irq), 0);
    wr(5, 16);
    chk("R12 irq enabled", int'(irq), 1);
    wr(5, 15);
    chk("R12 other enables", int'(irq), 0);
    wr(5, 31);
    wr(6, 16);
    chk("R12 irq after clear", int'(irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule